// File: doc/BRIEF.md
# Sized Add/Subtract Unit with Condition Codes

The unit adds or subtracts two register-wide operands at a selectable width of a quarter, half or full register. It returns the new register value and the next set of five condition flags: extend, negative, zero, overflow and carry. Extend-chained variants take the incoming extend flag as an extra carry or borrow, so that operands wider than one register can be built from several operations. A compare operation sets the flags from a subtraction and keeps the destination value. An address-destination path always works at full width. It sign-extends a half-width source and leaves every flag as it was.

The unit has one register stage. The caller presents an operation, a size, the destination and source values and the current flags together with `in_valid`. One clock later the result and flags appear with `out_valid`. The caller is responsible for instruction decoding, operand fetch and write-back.

Top module: `adsu_unit`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock. `result_o` and `ccr_o` load only in the cycle after `in_valid` is high and otherwise hold their values. Reset sets all three outputs to zero.
- R2: `size_i` selects the operand width for operations 0 to 4: 0 selects DW/4 bits, 1 selects DW/2 bits, and 2 or 3 select DW bits. For operations 0 to 3, the result bits above the selected width equal the matching bits of `dst_i`.
- R3: Operation 0 (add) writes the low n bits of `dst_i + src_i` into the result. Operation 2 (subtract) writes the low n bits of `dst_i - src_i`. Here n is the selected width.
- R4: For operations 0, 2 and 4, N equals bit n-1 of the n-bit difference or sum. Z is set exactly when those n bits are all zero.
- R5: `ccr_o` and `ccr_i` pack the flags as {X,N,Z,V,C} in bits 4 down to 0. V flags signed overflow at width n. C is the carry out of an add or the borrow of a subtract. For operations 0 to 3, X equals C.
- R6: Operation 1 (add with extend) adds X from `ccr_i` as a carry-in. Operation 3 (subtract with extend) subtracts it as a borrow. For these two operations Z is cleared when the n-bit result is nonzero, and otherwise keeps the Z of `ccr_i`.
- R7: Operation 4 (compare) sets N, Z, V and C from `dst_i - src_i` at width n. It returns `dst_i` unchanged as the result and copies X from `ccr_i`.
- R8: Operations 5 and 6 (address add and address subtract) work at full width DW. When `size_i` is 2 or 3 they use `src_i` as it is. Otherwise they sign-extend the low DW/2 bits of `src_i`. `ccr_o` equals `ccr_i`.
- R9: Operation 7 is a no-operation: the result equals `dst_i` and `ccr_o` equals `ccr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request is present this cycle |
| op_i | input | 3 | Operation code 0..7 |
| size_i | input | 2 | Operand width select |
| dst_i | input | DW | Destination operand |
| src_i | input | DW | Source operand |
| ccr_i | input | 5 | Current flags {X,N,Z,V,C} |
| out_valid | output | 1 | Result is present this cycle |
| result_o | output | DW | New destination value |
| ccr_o | output | 5 | Next flags {X,N,Z,V,C} |

## Verification
The assertions assume that `op_i`, `size_i`, `dst_i` and `ccr_i` are known values whenever `in_valid` is high, and that `in_valid` is low during reset. The checks that depend on the previous cycle compare against the inputs sampled with the request. The bench drives every input at the falling edge and keeps `in_valid` low throughout reset, so these assumptions hold. The sweep covers every code of the operation and size fields, including the spare size code and an address operation given the smallest size. The flag input varies with the operands, so the sticky zero behaviour and the extend carry are tried in both of their states.

// File: rtl/adsu_pkg.sv
package adsu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDX = 3'd1,
    OP_SUB  = 3'd2,
    OP_SUBX = 3'd3,
    OP_CMP  = 3'd4,
    OP_ADDA = 3'd5,
    OP_SUBA = 3'd6,
    OP_NOP  = 3'd7
  } adsu_op_e;

  // flag bits {X,N,Z,V,C}, bit 4 down to 0
  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } adsu_ccr_t;

  typedef struct packed {
    logic sub;
    logic ext;
    logic addr;
    logic cmp;
    logic pass;
  } adsu_ctl_t;

  function automatic adsu_ctl_t decode_op(adsu_op_e op);
    adsu_ctl_t c;
    c = '0;
    case (op)
      OP_ADD:  c = c;
      OP_ADDX: c.ext = 1'b1;
      OP_SUB:  c.sub = 1'b1;
      OP_SUBX: begin c.sub = 1'b1; c.ext = 1'b1; end
      OP_CMP:  begin c.sub = 1'b1; c.cmp = 1'b1; end
      OP_ADDA: c.addr = 1'b1;
      OP_SUBA: begin c.addr = 1'b1; c.sub = 1'b1; end
      default: c.pass = 1'b1;
    endcase
    return c;
  endfunction

  // lane 0 = quarter width, 1 = half, 2 = full; address path is always full
  function automatic logic [1:0] lane_of(logic [1:0] sz, logic addr);
    if (addr || sz[1]) return 2'd2;
    return sz[0] ? 2'd1 : 2'd0;
  endfunction

endpackage

// File: rtl/adsu_decode.sv
module adsu_decode
  import adsu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [2:0]    op_i,
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] src_i,
  input  logic          x_in,
  output adsu_ctl_t     ctl_o,
  output logic [1:0]    lane_o,
  output logic [DW-1:0] b_o,
  output logic          cin_o
);
  localparam int WW = DW / 2;

  logic ext_bit;

  always_comb begin
    ctl_o  = decode_op(adsu_op_e'(op_i));
    lane_o = lane_of(size_i, ctl_o.addr);
  end

  // address path: half-width source widened by its sign unless full size
  always_comb begin
    if (ctl_o.addr && !size_i[1]) b_o = {{WW{src_i[WW-1]}}, src_i[WW-1:0]};
    else                          b_o = src_i;
  end

  // subtract is a + ~b + 1; an extend borrow removes the +1
  assign ext_bit = ctl_o.ext & x_in;
  assign cin_o   = ctl_o.sub ? ~ext_bit : ext_bit;

endmodule

// File: rtl/adsu_lanes.sv
module adsu_lanes #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]      a_i,
  input  logic [DW-1:0]      b_i,
  input  logic               sub_i,
  input  logic               cin_i,
  output logic [2:0][DW-1:0] sum_o,
  output logic [2:0][DW-1:0] mask_o,
  output logic [2:0]         cout_o,
  output logic [2:0]         ovf_o,
  output logic [2:0]         neg_o,
  output logic [2:0]         zero_o
);

  for (genvar k = 0; k < 3; k++) begin : g_lane
    localparam int W = DW >> (2 - k);
    logic [W-1:0] bb;
    logic [W:0]   ext_sum;

    assign bb      = sub_i ? ~b_i[W-1:0] : b_i[W-1:0];
    assign ext_sum = {1'b0, a_i[W-1:0]} + {1'b0, bb} + (W+1)'(cin_i);

    assign sum_o[k]  = DW'(ext_sum[W-1:0]);
    assign mask_o[k] = DW'({W{1'b1}});
    assign cout_o[k] = ext_sum[W];
    assign ovf_o[k]  = (a_i[W-1] == bb[W-1]) && (ext_sum[W-1] != a_i[W-1]);
    assign neg_o[k]  = ext_sum[W-1];
    assign zero_o[k] = (ext_sum[W-1:0] == '0);
  end

endmodule

// File: rtl/adsu_ccr_gen.sv
module adsu_ccr_gen
  import adsu_pkg::*;
(
  input  adsu_ctl_t  ctl_i,
  input  logic [1:0] lane_i,
  input  logic [2:0] cout_i,
  input  logic [2:0] ovf_i,
  input  logic [2:0] neg_i,
  input  logic [2:0] zero_i,
  input  adsu_ccr_t  ccr_i,
  output adsu_ccr_t  ccr_o,
  output logic       carry_o,
  output logic       ovf_o
);

  logic raw_cout;

  assign raw_cout = cout_i[lane_i];
  assign carry_o  = ctl_i.sub ? ~raw_cout : raw_cout;
  assign ovf_o    = ovf_i[lane_i];

  always_comb begin
    if (ctl_i.pass || ctl_i.addr) begin
      ccr_o = ccr_i;
    end else begin
      ccr_o.n = neg_i[lane_i];
      ccr_o.v = ovf_o;
      ccr_o.c = carry_o;
      ccr_o.z = ctl_i.ext ? (zero_i[lane_i] & ccr_i.z) : zero_i[lane_i];
      ccr_o.x = ctl_i.cmp ? ccr_i.x : carry_o;
    end
  end

endmodule

// File: rtl/adsu_unit.sv
module adsu_unit
  import adsu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    op_i,
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] dst_i,
  input  logic [DW-1:0] src_i,
  input  logic [4:0]    ccr_i,
  output logic          out_valid,
  output logic [DW-1:0] result_o,
  output logic [4:0]    ccr_o
);

  adsu_ctl_t          w_ctl;
  logic [1:0]         w_lane;
  logic [DW-1:0]      w_b;
  logic               w_cin;
  logic [2:0][DW-1:0] w_sum;
  logic [2:0][DW-1:0] w_mask;
  logic [2:0]         w_cout;
  logic [2:0]         w_lovf;
  logic [2:0]         w_neg;
  logic [2:0]         w_zero;
  adsu_ccr_t          w_ccr_in;
  adsu_ccr_t          w_ccr_next;
  logic               w_sel_carry;
  logic               w_sel_ovf;
  logic [DW-1:0]      w_result;

  assign w_ccr_in = adsu_ccr_t'(ccr_i);

  adsu_decode #(.DW(DW)) u_decode (
    .op_i   (op_i),
    .size_i (size_i),
    .src_i  (src_i),
    .x_in   (w_ccr_in.x),
    .ctl_o  (w_ctl),
    .lane_o (w_lane),
    .b_o    (w_b),
    .cin_o  (w_cin)
  );

  adsu_lanes #(.DW(DW)) u_lanes (
    .a_i    (dst_i),
    .b_i    (w_b),
    .sub_i  (w_ctl.sub),
    .cin_i  (w_cin),
    .sum_o  (w_sum),
    .mask_o (w_mask),
    .cout_o (w_cout),
    .ovf_o  (w_lovf),
    .neg_o  (w_neg),
    .zero_o (w_zero)
  );

  adsu_ccr_gen u_ccr (
    .ctl_i   (w_ctl),
    .lane_i  (w_lane),
    .cout_i  (w_cout),
    .ovf_i   (w_lovf),
    .neg_i   (w_neg),
    .zero_i  (w_zero),
    .ccr_i   (w_ccr_in),
    .ccr_o   (w_ccr_next),
    .carry_o (w_sel_carry),
    .ovf_o   (w_sel_ovf)
  );

  // compare and no-op keep the destination; sized ops merge into it
  always_comb begin
    if (w_ctl.pass || w_ctl.cmp) w_result = dst_i;
    else if (w_ctl.addr)         w_result = w_sum[2];
    else                         w_result = (dst_i & ~w_mask[w_lane]) | w_sum[w_lane];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result_o  <= '0;
      ccr_o     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result_o <= w_result;
        ccr_o    <= w_ccr_next;
      end
    end
  end

endmodule

// File: rtl/adsu_unit_chk.sv
module adsu_unit_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [2:0]    op_i,
  input logic [1:0]    size_i,
  input logic [DW-1:0] dst_i,
  input logic [4:0]    ccr_i,
  input logic          out_valid,
  input logic [DW-1:0] result_o,
  input logic [4:0]    ccr_o,
  input logic          sel_carry
);
  localparam int BW = DW / 4;

  p_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result_o) && $stable(ccr_o)));

  p_upper_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_i <= 3'd3 && size_i == 2'd0)
      |=> result_o[DW-1:BW] == $past(dst_i[DW-1:BW]));

  p_x_is_c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_i <= 3'd3) |=> ccr_o[4] == ccr_o[0]);

  p_carry_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_i <= 3'd3) |=> ccr_o[0] == $past(sel_carry));

  p_zero_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_i == 3'd1 || op_i == 3'd3) && !ccr_i[2]) |=> !ccr_o[2]);

  p_cmp_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_i == 3'd4)
      |=> (result_o == $past(dst_i) && ccr_o[4] == $past(ccr_i[4])));

  p_addr_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_i == 3'd5 || op_i == 3'd6)) |=> ccr_o == $past(ccr_i));

  p_nop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_i == 3'd7)
      |=> (result_o == $past(dst_i) && ccr_o == $past(ccr_i)));

endmodule

bind adsu_unit adsu_unit_chk #(.DW(DW)) u_adsu_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_i      (op_i),
  .size_i    (size_i),
  .dst_i     (dst_i),
  .ccr_i     (ccr_i),
  .out_valid (out_valid),
  .result_o  (result_o),
  .ccr_o     (ccr_o),
  .sel_carry (w_sel_carry)
);

// File: tb/adsu_unit_bench.sv
`timescale 1ns/1ps
module adsu_unit_bench;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [2:0]    op_i = '0;
  logic [1:0]    size_i = '0;
  logic [DW-1:0] dst_i = '0;
  logic [DW-1:0] src_i = '0;
  logic [4:0]    ccr_i = '0;
  logic          out_valid;
  logic [DW-1:0] result_o;
  logic [4:0]    ccr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  adsu_unit #(.DW(DW)) u_adsu_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_i(op_i),
    .size_i(size_i), .dst_i(dst_i), .src_i(src_i), .ccr_i(ccr_i),
    .out_valid(out_valid), .result_o(result_o), .ccr_o(ccr_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // arithmetic model at DW=8: widths 2, 4, 8
  task automatic model(input int op, input int sz, input int d, input int s,
                       input int ci, output int r, output int co);
    int n, m, a, b, xi, zi, cin, sa, sb, raw, sraw, rr, c, v, nn, z, x, sv, half;
    bit ex, issub;
    if (op == 5 || op == 6) begin
      if (sz >= 2) sv = s;
      else sv = (s & 8) ? ((s & 15) | 'hF0) : (s & 15);
      r  = ((op == 5) ? d + sv : d - sv) & 255;
      co = ci;
    end else if (op == 7) begin
      r  = d;
      co = ci;
    end else begin
      n = (sz == 0) ? 2 : (sz == 1) ? 4 : 8;
      m = (1 << n) - 1;
      half = 1 << (n - 1);
      a = d & m;
      b = s & m;
      xi = (ci >> 4) & 1;
      zi = (ci >> 2) & 1;
      ex = (op == 1 || op == 3);
      issub = (op >= 2);
      cin = ex ? xi : 0;
      sa = (a >= half) ? a - (1 << n) : a;
      sb = (b >= half) ? b - (1 << n) : b;
      if (issub) begin
        raw = a - b - cin; sraw = sa - sb - cin; c = (raw < 0) ? 1 : 0;
      end else begin
        raw = a + b + cin; sraw = sa + sb + cin; c = (raw > m) ? 1 : 0;
      end
      v  = (sraw > half - 1 || sraw < -half) ? 1 : 0;
      rr = raw & m;
      nn = (rr >> (n - 1)) & 1;
      z  = (rr == 0) ? 1 : 0;
      if (ex) z = z & zi;
      x  = (op == 4) ? xi : c;
      co = (x << 4) | (nn << 3) | (z << 2) | (v << 1) | c;
      r  = (op == 4) ? d : ((d & ~m & 255) | rr);
    end
  endtask

  function automatic string res_tag(int op);
    case (op)
      0, 2:    return "R3";
      1, 3:    return "R6";
      4:       return "R7";
      5, 6:    return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic string ccr_tag(int op);
    case (op)
      0, 2:    return "R5";
      1, 3:    return "R6";
      4:       return "R7";
      5, 6:    return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    int er, ec, held_r, held_c;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset out_valid", out_valid, 0);
    chk("R1 reset result", result_o, 0);
    chk("R1 reset ccr", ccr_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int op = 0; op < 8; op++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int d = 0; d < 256; d += 7) begin
          for (int s = 0; s < 256; s += 7) begin
            int ci;
            ci = (d ^ (s >> 1) ^ (op * 5) ^ sz) & 31;
            in_valid = 1'b1;
            op_i = 3'(op); size_i = 2'(sz);
            dst_i = 8'(d); src_i = 8'(s); ccr_i = 5'(ci);
            model(op, sz, d, s, ci, er, ec);
            @(negedge clk);
            chk("R1 out_valid", out_valid, 1);
            chk(res_tag(op), result_o, er);
            chk(ccr_tag(op), ccr_o, ec);
            if (op == 0 || op == 2 || op == 4)
              chk("R4 N and Z", (ccr_o >> 2) & 3, (ec >> 2) & 3);
            if (op <= 3 && sz <= 1)
              chk("R2 upper bits", result_o & ((sz == 0) ? 'hFC : 'hF0),
                  d & ((sz == 0) ? 'hFC : 'hF0));
            in_valid = 1'b0;
            @(negedge clk);
          end
        end
      end
    end

    // R1 idle inputs have no effect on outputs
    held_r = result_o;
    held_c = ccr_o;
    in_valid = 1'b0;
    op_i = 3'd0; size_i = 2'd2; dst_i = 8'h5A; src_i = 8'h33; ccr_i = 5'h1F;
    @(negedge clk);
    @(negedge clk);
    chk("R1 idle out_valid", out_valid, 0);
    chk("R1 idle result hold", result_o, held_r);
    chk("R1 idle ccr hold", ccr_o, held_c);

    // R6 chained extend across two bytes: 0x01FF + 0x0001 at DW=8 long
    in_valid = 1'b1; op_i = 3'd0; size_i = 2'd2; dst_i = 8'hFF; src_i = 8'h01; ccr_i = 5'h00;
    @(negedge clk);
    chk("R3 low part", result_o, 8'h00);
    chk("R5 low part ccr", ccr_o, 5'b10101);
    op_i = 3'd1; dst_i = 8'h01; src_i = 8'h00; ccr_i = ccr_o;
    @(negedge clk);
    chk("R6 high part", result_o, 8'h02);
    chk("R6 high part ccr", ccr_o, 5'b00000);
    in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 190000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule